// File: doc/BRIEF.md
# Dual Extended Accumulator with Saturating Readout

This block holds two fractional accumulators, selected by a one-bit index (0 and 1). Each accumulator is 56 bits wide. It has an 8-bit guard extension on top, a 24-bit high word in the middle and a 24-bit low word at the bottom. The binary point sits just below the guard extension.

A data bus writes the accumulators in one of three sizes: a single word, a long word, or the guard byte alone. Word and long-word writes keep the binary point aligned: the top bit of the written value is copied through the guard byte.

Reads are combinational. They come in the same sizes. A word or long-word read returns the largest value of the correct sign when the guard bits carry significance, and does not truncate. A sticky flag records that such limiting took place, and stays set until it is explicitly cleared.

Top module: `acc_pair_limiter`

## Requirements
- R1: After reset both accumulators hold zero and `limit_flag` is 0.
- R2: A write with size 0 (word) copies `wr_data[23:0]` into the high word, copies bit 23 of it into all 8 guard bits, and clears the low word. The new value is visible on reads from the next cycle.
- R3: A write with size 1 (long) places `wr_data[47:24]` in the high word and `wr_data[23:0]` in the low word, and copies bit 47 into all 8 guard bits.
- R4: A write with size 2 (guard) replaces only the guard byte with `wr_data[7:0]`. Both words are kept.
- R5: A write with size 3 changes nothing.
- R6: The guard is "in use" when accumulator bits 55 down to 47 are not all equal. A word read (size 0) of an accumulator with the guard in use returns 0x7FFFFF when bit 55 is 0 and 0x800000 when bit 55 is 1, in `rd_data[23:0]`, with the upper bits zero.
- R7: A long read (size 1) of an accumulator with the guard in use returns 0x7FFFFFFFFFFF when bit 55 is 0 and 0x800000000000 when bit 55 is 1.
- R8: When the guard is not in use, a word read returns the high word unchanged and a long read returns the high and low words unchanged.
- R9: A read with size 2 returns the guard byte in `rd_data[7:0]` with the other bits zero, and never limits. A read with size 3 returns zero.
- R10: A clock edge with `rd_en` high and a limiting word or long read sets `limit_flag` from the next cycle on. The flag stays set afterwards. A set in the same cycle as a clear wins.
- R11: `limit_clr` high at an edge with no limiting read clears `limit_flag`.
- R12: A write alters only the accumulator named by `wr_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Accumulator written (0 or 1) |
| wr_size | input | 2 | Write size: 0 word, 1 long, 2 guard, 3 none |
| wr_data | input | 48 | Write data |
| rd_en | input | 1 | Marks a read that counts toward the flag |
| rd_sel | input | 1 | Accumulator read |
| rd_size | input | 2 | Read size: 0 word, 1 long, 2 guard, 3 none |
| rd_data | output | 48 | Read data, combinational |
| limit_clr | input | 1 | Clears the sticky flag |
| limit_flag | output | 1 | Sticky limiting indicator |

## Verification
The bench goes after the boundary of the in-use test. A guard byte of all ones over a negative high word must read back raw. A design that compared only the guard byte, or left out bit 47, would clamp values that fit, or pass through values that overflow. Guard writes over positive and negative words check the clamp polarity; a design that took the sign from bit 47 would saturate in the wrong direction. Word writes over a dirty low word catch a failure to clear it. A clear issued in the same cycle as a limiting read checks that the set is not lost.

// File: rtl/acc_pair_limiter.sv
module acc_pair_limiter #(
  parameter int EXT_W  = 8,
  parameter int WORD_W = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  wr_sel,
  input  logic [1:0]            wr_size,
  input  logic [2*WORD_W-1:0]   wr_data,
  input  logic                  rd_en,
  input  logic                  rd_sel,
  input  logic [1:0]            rd_size,
  output logic [2*WORD_W-1:0]   rd_data,
  input  logic                  limit_clr,
  output logic                  limit_flag
);
  localparam int LONG_W = 2 * WORD_W;
  localparam int ACC_W  = EXT_W + LONG_W;
  localparam logic [WORD_W-1:0] WORD_MAX = {1'b0, {(WORD_W-1){1'b1}}};
  localparam logic [WORD_W-1:0] WORD_MIN = {1'b1, {(WORD_W-1){1'b0}}};
  localparam logic [LONG_W-1:0] LONG_MAX = {1'b0, {(LONG_W-1){1'b1}}};
  localparam logic [LONG_W-1:0] LONG_MIN = {1'b1, {(LONG_W-1){1'b0}}};

  logic [ACC_W-1:0] acc_q [2];
  logic [ACC_W-1:0] rd_acc;
  logic             in_use, neg, clamping;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q[0] <= '0;
      acc_q[1] <= '0;
    end else if (wr_en) begin
      case (wr_size)
        2'd0: acc_q[wr_sel] <= {{EXT_W{wr_data[WORD_W-1]}}, wr_data[WORD_W-1:0], {WORD_W{1'b0}}};
        2'd1: acc_q[wr_sel] <= {{EXT_W{wr_data[LONG_W-1]}}, wr_data};
        2'd2: acc_q[wr_sel][ACC_W-1:LONG_W] <= wr_data[EXT_W-1:0];
        default: ;
      endcase
    end
  end

  assign rd_acc   = acc_q[rd_sel];
  assign neg      = rd_acc[ACC_W-1];
  assign in_use   = !(&rd_acc[ACC_W-1:LONG_W-1]) && (|rd_acc[ACC_W-1:LONG_W-1]);
  assign clamping = in_use && (rd_size == 2'd0 || rd_size == 2'd1);

  always_comb begin
    rd_data = '0;
    case (rd_size)
      2'd0: rd_data[WORD_W-1:0] = in_use ? (neg ? WORD_MIN : WORD_MAX) : rd_acc[LONG_W-1:WORD_W];
      2'd1: rd_data = in_use ? (neg ? LONG_MIN : LONG_MAX) : rd_acc[LONG_W-1:0];
      2'd2: rd_data[EXT_W-1:0] = rd_acc[ACC_W-1:LONG_W];
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   limit_flag <= 1'b0;
    else if (rd_en && clamping)   limit_flag <= 1'b1;
    else if (limit_clr)           limit_flag <= 1'b0;
  end

  a_r2_word_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_size == 2'd0 && !wr_sel |=>
      acc_q[0] == {{EXT_W{$past(wr_data[WORD_W-1])}}, $past(wr_data[WORD_W-1:0]), {WORD_W{1'b0}}});
  a_r3_long_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_size == 2'd1 && wr_sel |=>
      acc_q[1] == {{EXT_W{$past(wr_data[LONG_W-1])}}, $past(wr_data)});
  a_r10_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && clamping |=> limit_flag);
  a_r11_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    limit_clr && !(rd_en && clamping) |=> !limit_flag);
  a_r12_other_kept: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_sel |=> $stable(acc_q[1]));
endmodule

// File: tb/acc_pair_limiter_test.sv
module acc_pair_limiter_test;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_sel = 0, rd_en = 0, rd_sel = 0, limit_clr = 0;
  logic [1:0] wr_size = 0, rd_size = 0;
  logic [47:0] wr_data = 0;
  logic [47:0] rd_data;
  logic limit_flag;
  int checks = 0, fails = 0;
  logic [55:0] m_acc [2];
  logic m_flag;

  always #2.5 clk = ~clk;

  acc_pair_limiter uut (.clk, .rst_n, .wr_en, .wr_sel, .wr_size, .wr_data, .rd_en,
    .rd_sel, .rd_size, .rd_data, .limit_clr, .limit_flag);

  function automatic logic used(input logic [55:0] a);
    return !(a[55:47] == 9'h000 || a[55:47] == 9'h1FF);
  endfunction

  function automatic logic [47:0] exp_rd(input logic [55:0] a, input logic [1:0] sz);
    case (sz)
      2'd0: return used(a) ? (a[55] ? 48'h800000 : 48'h7FFFFF) : {24'h0, a[47:24]};
      2'd1: return used(a) ? (a[55] ? 48'h800000000000 : 48'h7FFFFFFFFFFF) : a[47:0];
      2'd2: return {40'h0, a[55:48]};
      default: return 48'h0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, check combinational read and flag, then advance the model at posedge
  task automatic step(input logic we, input logic ws, input logic [1:0] wz, input logic [47:0] wd,
                      input logic re, input logic rs, input logic [1:0] rz, input logic cl,
                      input string req);
    logic set;
    @(negedge clk);
    wr_en = we; wr_sel = ws; wr_size = wz; wr_data = wd;
    rd_en = re; rd_sel = rs; rd_size = rz; limit_clr = cl;
    #1;
    chk(req, rd_data, exp_rd(m_acc[rs], rz));
    chk("R10/R11 flag", {47'h0, limit_flag}, {47'h0, m_flag});
    set = re && (rz < 2) && used(m_acc[rs]);
    @(posedge clk);
    if (we) case (wz)
      2'd0: m_acc[ws] = {{8{wd[23]}}, wd[23:0], 24'h0};
      2'd1: m_acc[ws] = {{8{wd[47]}}, wd};
      2'd2: m_acc[ws][55:48] = wd[7:0];
      default: ;
    endcase
    m_flag = set ? 1'b1 : (cl ? 1'b0 : m_flag);
  endtask

  initial begin
    #20000000;
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(13));
    m_acc[0] = 0; m_acc[1] = 0; m_flag = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    step(0,0,0,0, 0,0,1,0, "R1 reset A");
    step(0,0,0,0, 0,1,1,0, "R1 reset B");
    // R2 word write over a dirty low word
    step(1,0,1,48'h123456_ABCDEF, 0,0,1,0, "R3 long");
    step(1,0,0,48'h000000_812345, 0,0,1,0, "R3 long read");
    step(0,0,0,0, 0,0,1,0, "R2 word sign ext low cleared");
    step(0,0,0,0, 0,0,2,0, "R2 guard of word write");
    // R4 guard write, positive high word -> clamp high
    step(1,1,0,48'h400000, 0,1,3,0, "R9 none read");
    step(1,1,2,48'h01, 0,1,0,0, "R8 plain word");
    step(0,0,0,0, 1,1,0,0, "R6 word clamp positive");
    step(0,0,0,0, 1,1,1,0, "R7 long clamp positive");
    step(0,0,0,0, 0,1,2,1, "R4 guard read");
    // R6 negative clamp and boundary: all-ones guard over negative word fits
    step(1,1,2,48'hFF, 0,0,0,0, "R12 A untouched");
    step(0,0,0,0, 1,1,0,0, "R6 word clamp negative");
    step(1,1,0,48'h800000, 1,1,1,1, "R10 set wins over clear");
    step(0,0,0,0, 1,1,1,0, "R8 boundary no clamp");
    step(0,0,0,0, 0,1,0,1, "R8 boundary word");
    // R5 size 3 write no effect
    step(1,1,3,48'hFFFFFFFFFFFF, 0,1,1,0, "R5 before");
    step(0,0,0,0, 0,1,1,0, "R5 no effect");
    step(1,0,2,48'h80, 0,0,1,0, "R7 setup");
    step(0,0,0,0, 1,0,1,0, "R7 long clamp negative");
    // random phase
    for (int i = 0; i < 600; i++) begin
      logic [1:0] wz = 2'($urandom_range(0,3));
      logic [47:0] wd = {$urandom(), $urandom()} & 48'hFFFFFFFFFFFF;
      step(1'($urandom_range(0,1)), 1'($urandom_range(0,1)), wz, wd,
           1'($urandom_range(0,1)), 1'($urandom_range(0,1)), 2'($urandom_range(0,3)),
           ($urandom_range(0,7) == 0), "R6/R7/R8 random");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule